// File: doc/BRIEF.md
# Serial Command Frame Shifter with Chain Output

This block is the receive and return path of a four-wire serial slave. While the active-low select is held low, it samples the data input on each rising edge of the serial clock into a 16-bit shift register, most significant bit first. When the select returns high, it latches the newest 16 bits as a command and presents them as one parallel strobe. That strobe carries a direction bit, a 7-bit register address and a data byte.

The serial output follows the top bit of the shift register and updates only on falling edges of the serial clock. A bit therefore leaves the block 15.5 serial clocks after it entered. This lets several blocks share one select and one clock in a chain, with 16 clocks per device. For a read command, the select rise raises a read request with the address. The returned byte overwrites the low byte of the shift register, so the next frame carries it out as its second byte.

All serial pins are asynchronous to the system clock. They pass through a parameterised synchroniser, and edges are detected in the system clock domain.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset the serial output is 0, the command strobe is low, and the command fields read zero. The shift register starts at all zeros.
- R2: Each serial clock rising edge seen while select is low shifts the data input into bit 0 of the frame, most significant bit first. Bit 15 is the direction (1 = read, 0 = write), bits 14..8 are the address and bits 7..0 are the data.
- R3: Each select rising edge produces exactly one one-cycle `cmd_valid_o` pulse. The direction, address and data fields hold the latched frame until the next pulse.
- R4: When more than 16 bits are clocked in one select window, only the last 16 bits are latched.
- R5: When fewer than 16 bits are clocked, the upper frame positions hold bits left over from earlier frames, shifted up by the number of new bits.
- R6: While select is high, serial clock and data activity changes neither the frame nor the serial output.
- R7: The serial output takes frame bit 15 on each serial clock falling edge seen while select is low. It therefore repeats the input stream 15.5 serial clocks later and is stable across every rising edge.
- R8: When a read frame is latched, `rd_req_o` pulses in the same cycle with the frame address on `rd_addr_o`. The `rd_data_i` byte replaces frame bits 7..0, and the next frame shifts it out on the serial output as bits 8..15 of its stream.
- R9: A latched write frame raises no read request.
- R10: A final serial clock rising edge that reaches the block in the same system cycle as the select rise is counted as part of the frame.
- R11: The serial output is always driven to 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Active-low select, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (chain output / readback) |
| cmd_valid_o | output | 1 | One-cycle pulse per latched frame |
| cmd_rw_o | output | 1 | Latched direction, 1 = read |
| cmd_addr_o | output | 7 | Latched register address |
| cmd_data_o | output | 8 | Latched data byte |
| rd_req_o | output | 1 | Read request, same cycle as select rise |
| rd_addr_o | output | 7 | Address of the read request |
| rd_data_i | input | 8 | Register value returned for the read request |

## Verification
Two events can land in the same system cycle: the last serial clock rise and the select rise. The bench provokes this by raising the serial clock and the select together, so both cross the synchroniser in the same cycle. The bench then judges the latched frame against a model that counts that last bit. Coincident read frames must also load the read-back byte. The bench checks this bit by bit on the serial output of the following frame.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;

    typedef struct packed {
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sfs_edge.sv
module sfs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic csn_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel_rise
);
    typedef struct packed {
        logic sclk_prev;
        logic csn_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.sclk_prev = sclk_s;
        st_d.csn_prev  = csn_s;
        // serial clock edges count only while the select was already low
        sclk_rise = sclk_s & ~st_q.sclk_prev & ~st_q.csn_prev;
        sclk_fall = ~sclk_s & st_q.sclk_prev & ~st_q.csn_prev;
        sel_rise  = csn_s & ~st_q.csn_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sclk_prev: 1'b0, csn_prev: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sfs_shift.sv
module sfs_shift #(
    parameter int FRAME_W = 16,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               fall_en,
    input  logic               sdi,
    input  logic               load_en,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [FRAME_W-1:0] frame_next,
    output logic [FRAME_W-1:0] frame_q,
    output logic               sdo
);
    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic               out;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        frame_next = shift_en ? {st_q.sreg[FRAME_W-2:0], sdi} : st_q.sreg;
        st_d.sreg  = frame_next;
        if (load_en && frame_next[FRAME_W-1]) begin
            st_d.sreg[DATA_W-1:0] = rd_data;
        end
        st_d.out = fall_en ? st_q.sreg[FRAME_W-1] : st_q.out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_q = st_q.sreg;
    assign sdo     = st_q.out;
endmodule

// File: rtl/sfs_capture.sv
module sfs_capture (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  sfs_pkg::frame_t frame_in,
    output logic            valid,
    output sfs_pkg::frame_t frame_out
);
    typedef struct packed {
        logic            valid;
        sfs_pkg::frame_t frame;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d.valid = take;
        st_d.frame = take ? frame_in : st_q.frame;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid     = st_q.valid;
    assign frame_out = st_q.frame;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       csn_i,
    input  logic       sdi_i,
    output logic       sdo_o,
    output logic       cmd_valid_o,
    output logic       cmd_rw_o,
    output logic [6:0] cmd_addr_o,
    output logic [7:0] cmd_data_o,
    output logic       rd_req_o,
    output logic [6:0] rd_addr_o,
    input  logic [7:0] rd_data_i
);
    import sfs_pkg::*;

    localparam int PIN_W = 3;

    logic [PIN_W-1:0]   pins_s;
    logic               sclk_rise, sclk_fall, sel_rise;
    logic [FRAME_W-1:0] frame_next, frame_q;
    frame_t             next_frame, cap_frame;

    sfs_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({csn_i, sclk_i, sdi_i}),
        .dout (pins_s)
    );

    sfs_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[1]),
        .csn_s    (pins_s[2]),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sel_rise (sel_rise)
    );

    sfs_shift #(
        .FRAME_W(FRAME_W),
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (sclk_rise),
        .fall_en   (sclk_fall),
        .sdi       (pins_s[0]),
        .load_en   (sel_rise),
        .rd_data   (rd_data_i),
        .frame_next(frame_next),
        .frame_q   (frame_q),
        .sdo       (sdo_o)
    );

    assign next_frame = frame_t'(frame_next);

    sfs_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (sel_rise),
        .frame_in (next_frame),
        .valid    (cmd_valid_o),
        .frame_out(cap_frame)
    );

    assign cmd_rw_o   = cap_frame.rw;
    assign cmd_addr_o = cap_frame.addr;
    assign cmd_data_o = cap_frame.data;
    assign rd_req_o   = sel_rise & next_frame.rw;
    assign rd_addr_o  = next_frame.addr;
endmodule

// File: rtl/spi_cmd_shifter_chk.sv
module spi_cmd_shifter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid_o,
    input logic        cmd_rw_o,
    input logic [6:0]  cmd_addr_o,
    input logic [7:0]  cmd_data_o,
    input logic        rd_req_o,
    input logic [7:0]  rd_data_i,
    input logic        sdo_o,
    input logic        sclk_fall,
    input logic [15:0] frame_q
);
    // R3
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> $stable({cmd_rw_o, cmd_addr_o, cmd_data_o}));

    // R8
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> (cmd_valid_o && cmd_rw_o));

    // R8
    rb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> (frame_q[7:0] == $past(rd_data_i)));

    // R9
    wr_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_rw_o) |-> !$past(rd_req_o));

    // R7
    sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> $past(sclk_fall));
endmodule

bind spi_cmd_shifter spi_cmd_shifter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid_o(cmd_valid_o),
    .cmd_rw_o   (cmd_rw_o),
    .cmd_addr_o (cmd_addr_o),
    .cmd_data_o (cmd_data_o),
    .rd_req_o   (rd_req_o),
    .rd_data_i  (rd_data_i),
    .sdo_o      (sdo_o),
    .sclk_fall  (sclk_fall),
    .frame_q    (frame_q)
);

// File: tb/tb_spi_cmd_shifter.sv
module tb_spi_cmd_shifter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       csn = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       cmd_valid, cmd_rw, rd_req;
    logic [6:0] cmd_addr, rd_addr;
    logic [7:0] cmd_data, rd_data;

    int nchk = 0;
    int nfail = 0;
    int vcnt = 0;
    int rcnt = 0;
    int vexp = 0;
    int rexp = 0;
    logic [15:0] model = 16'h0000;
    logic        prev_read = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] rdfun(input logic [6:0] a);
        return {a[3:0], ~a[6:4], 1'b1};
    endfunction

    assign rd_data = rdfun(rd_addr);

    spi_cmd_shifter dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
        .sdo_o(sdo), .cmd_valid_o(cmd_valid), .cmd_rw_o(cmd_rw),
        .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .rd_req_o(rd_req),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    always @(negedge clk) begin
        if (cmd_valid) vcnt <= vcnt + 1;
        if (rd_req)    rcnt <= rcnt + 1;
    end

    typedef struct packed {
        logic [31:0] bits;
        logic [5:0]  nbits;
        logic [1:0]  mode;   // 0 clock low before select rise, 1 select rise with clock high, 2 coincident
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0155, 6'd16, 2'd0},
        '{32'h0000_8A00, 6'd16, 2'd0},
        '{32'h0000_2000, 6'd16, 2'd0},
        '{32'h000A_BCDE, 6'd20, 2'd0},
        '{32'h0000_003C, 6'd8,  2'd0},
        '{32'h0000_7FFF, 6'd16, 2'd1},
        '{32'h0000_9301, 6'd16, 2'd2},
        '{32'h0000_0000, 6'd16, 2'd0},
        '{32'h0012_8544, 6'd24, 2'd0},
        '{32'h0000_0001, 6'd1,  2'd0},
        '{32'h0000_C2A5, 6'd16, 2'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] bits, input int nbits, input int mode);
        string freq;
        csn = 1'b0;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            int k;
            k = nbits - i;
            sdi = bits[i];
            wait_clk(4);
            if (k >= 2) begin
                if (prev_read && k >= 9 && k <= 16) chk("R8 readback on sdo", 32'(sdo), 32'(model[15]));
                else                                chk("R7 sdo lag", 32'(sdo), 32'(model[15]));
            end
            chk("R11 sdo driven", 32'(^sdo === 1'bx), 32'd0);
            if (i == 0 && mode == 2) begin
                sclk = 1'b1;
                csn  = 1'b1;
            end else begin
                sclk = 1'b1;
            end
            model = {model[14:0], bits[i]};
            wait_clk(4);
            if (i > 0 || mode == 0) sclk = 1'b0;
        end
        if (mode == 0 || nbits == 0) begin
            wait_clk(4);
            csn = 1'b1;
        end else if (mode == 1) begin
            csn = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end else begin
            wait_clk(4);
            sclk = 1'b0;
        end
        begin
            logic [15:0] exp_frame;
            exp_frame = model;
            vexp++;
            if (exp_frame[15]) begin
                rexp++;
                model[7:0] = rdfun(exp_frame[14:8]);
            end
            wait_clk(10);
            if (mode == 2)        freq = "R10 coincident edge";
            else if (nbits > 16)  freq = "R4 long frame";
            else if (nbits < 16)  freq = "R5 short frame";
            else                  freq = "R2 frame fields";
            chk(freq, {16'h0, cmd_rw, cmd_addr, cmd_data}, {16'h0, exp_frame});
            chk("R3 one strobe per frame", vcnt, vexp);
            if (exp_frame[15]) chk("R8 read request count", rcnt, rexp);
            else               chk("R9 no request on write", rcnt, rexp);
            prev_read = exp_frame[15];
        end
    endtask

    initial begin
        #(20 * 200000);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        wait_clk(3);
        // R1 reset state while held in reset and just after release
        chk("R1 sdo reset", 32'(sdo), 32'd0);
        chk("R1 strobe reset", 32'(cmd_valid), 32'd0);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R1 fields reset", {16'h0, cmd_rw, cmd_addr, cmd_data}, 32'd0);
        chk("R1 no read request", 32'(rcnt), 32'd0);

        for (int v = 0; v < NV; v++) begin
            send(VECS[v].bits, int'(VECS[v].nbits), int'(VECS[v].mode));
        end

        // R6: toggling clock and data with select high changes nothing
        begin
            logic        sdo_before;
            logic [15:0] frame_before;
            sdo_before = sdo;
            frame_before = model;
            for (int t = 0; t < 6; t++) begin
                sdi  = t[0];
                sclk = 1'b1;
                wait_clk(4);
                sclk = 1'b0;
                wait_clk(4);
            end
            chk("R6 sdo unchanged", 32'(sdo), 32'(sdo_before));
            chk("R6 no strobe", vcnt, vexp);
            send(32'h0, 0, 0);
            chk("R6 frame unchanged", {16'h0, cmd_rw, cmd_addr, cmd_data}, {16'h0, frame_before});
        end

        // follow-up frame to shift out the read-back loaded by the empty frame (if any)
        send(32'h0000_1133, 16, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule